// File: doc/BRIEF.md
# Open-Row DRAM Command Sequencer

This block turns cache-line read and write requests into a stream of DRAM commands on a single command/address bus. The bus is shared by every bank of two ranks. Each request names a rank, a bank, a row and a column. The block remembers, for every bank of every rank, whether a row is latched in its sense amplifiers and which row that is. It uses an open-row policy, so a row stays open after an access.

For each request it picks one of three command sequences:

- **Row already open:** the column commands only.
- **Bank closed:** an activate, then the column commands.
- **Different row open:** a precharge, an activate, then the column commands.

A 64-byte line moves as eight column commands to consecutive columns of one row. A one-cycle done pulse marks the last of the eight.

A separate close request precharges a bank if it holds an open row, and does nothing otherwise. The block accepts one request at a time through a valid/ready handshake. Per-bank down-counters hold off each command until three minimum delays have passed: activate to column, precharge to activate, and activate to precharge.

Top module: `dram_cmd_seq`

## Requirements
- R1: Reset sets every bank to the closed state. During reset and the cycle after it, `cmd_o` is NOP (0), `done_o` is low and `req_ready` is high.
- R2: A read or write to a bank with no open row issues ACT (code 1) with the request row on `cmd_addr_o`, then the column commands.
- R3: A read or write whose row is already open in that bank issues no ACT and no PRE, only the column commands.
- R4: A read or write that finds a different row open issues PRE (code 4), then ACT with the new row, then the column commands.
- R5: A line access issues eight column commands, RD (code 2) for request op 0 and WR (code 3) for op 1, in eight consecutive cycles. Command k (0 to 7) carries column {req_col[10:3], k}, zero-extended on `cmd_addr_o`. The low three column bits of the request are ignored.
- R6: `done_o` is high for exactly one cycle per line access, in the cycle the eighth column command is on `cmd_o`.
- R7: A column command to a bank comes at least T_RCD cycles after that bank's last ACT.
- R8: An ACT to a bank comes at least T_RP cycles after that bank's last PRE.
- R9: A PRE to a bank comes at least T_RAS cycles after that bank's last ACT.
- R10: A close request (op 2) to a bank with an open row issues one PRE to it and no done pulse. A later read or write to that bank starts with ACT.
- R11: A close request to a closed bank issues no command and no done pulse, and `req_ready` returns high.
- R12: Open-row state is kept separately for each rank and bank. `cmd_cs_o` and `cmd_bank_o` carry the request's rank and bank on every command.
- R13: At most one command appears per cycle. `req_ready` is low from the cycle after an accepted request until its sequence is complete.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block is idle and accepts a request |
| req_op | input | 2 | 0 read line, 1 write line, 2 close bank |
| req_rank | input | 1 | Rank select |
| req_bank | input | 3 | Bank index |
| req_row | input | 14 | Row index |
| req_col | input | 11 | Column index (low 3 bits ignored) |
| cmd_o | output | 3 | 0 NOP, 1 ACT, 2 RD, 3 WR, 4 PRE |
| cmd_cs_o | output | 1 | Rank chip select for the command |
| cmd_bank_o | output | 3 | Bank of the command |
| cmd_addr_o | output | 14 | Row for ACT, column for RD/WR |
| done_o | output | 1 | Last beat of a line access issued |

## Verification
Line accesses are driven into three kinds of bank:

- **Closed:** shows whether the block activates first.
- **Holding the same row:** shows whether it skips the activate.
- **Holding another row:** shows whether it precharges before activating.

A conflict sent straight after an activate stresses the activate-to-precharge hold. A read sent straight after a close stresses the precharge-to-activate hold.

Close requests go to an open bank and to a closed bank, which tells a real precharge from a no-op. A request to the same bank number in the other rank shows whether open-row state is kept per rank. Beat addresses use a column with nonzero low bits, so a design that does not align the column is caught.

// File: rtl/dcs_pkg.sv
package dcs_pkg;
  typedef enum logic [2:0] {
    CMD_NOP = 3'd0,
    CMD_ACT = 3'd1,
    CMD_RD  = 3'd2,
    CMD_WR  = 3'd3,
    CMD_PRE = 3'd4
  } cmd_e;

  typedef enum logic [1:0] {
    OP_RD    = 2'd0,
    OP_WR    = 2'd1,
    OP_CLOSE = 2'd2
  } op_e;

  typedef enum logic [2:0] {
    S_IDLE,
    S_DECIDE,
    S_PRE,
    S_ACT,
    S_COL
  } seq_state_e;
endpackage

// File: rtl/dcs_bank_track.sv
module dcs_bank_track #(
  parameter int ROW_W = 14,
  parameter int CNT_W = 5,
  parameter int T_RCD = 3,
  parameter int T_RP  = 4,
  parameter int T_RAS = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             act_i,
  input  logic             pre_i,
  input  logic [ROW_W-1:0] row_i,
  output logic             open_o,
  output logic [ROW_W-1:0] row_o,
  output logic             rcd_ok_o,
  output logic             rp_ok_o,
  output logic             ras_ok_o
);
  logic [CNT_W-1:0] rcd_cnt, rp_cnt, ras_cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      open_o  <= 1'b0;
      row_o   <= '0;
      rcd_cnt <= '0;
      rp_cnt  <= '0;
      ras_cnt <= '0;
    end else begin
      if (act_i) begin
        open_o  <= 1'b1;
        row_o   <= row_i;
        rcd_cnt <= CNT_W'(T_RCD - 1);
        ras_cnt <= CNT_W'(T_RAS - 1);
      end else begin
        if (rcd_cnt != '0) rcd_cnt <= rcd_cnt - 1'b1;
        if (ras_cnt != '0) ras_cnt <= ras_cnt - 1'b1;
      end
      if (pre_i) begin
        open_o <= 1'b0;
        rp_cnt <= CNT_W'(T_RP - 1);
      end else if (rp_cnt != '0) begin
        rp_cnt <= rp_cnt - 1'b1;
      end
    end
  end

  assign rcd_ok_o = (rcd_cnt == '0);
  assign rp_ok_o  = (rp_cnt == '0);
  assign ras_ok_o = (ras_cnt == '0);
endmodule

// File: rtl/dcs_beat_ctr.sv
module dcs_beat_ctr #(
  parameter int BEATS  = 8,
  parameter int BEAT_W = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr_i,
  input  logic              inc_i,
  output logic [BEAT_W-1:0] beat_o,
  output logic              last_o
);
  always_ff @(posedge clk) begin
    if (rst || clr_i) beat_o <= '0;
    else if (inc_i)   beat_o <= (last_o) ? '0 : beat_o + 1'b1;
  end

  assign last_o = (beat_o == BEAT_W'(BEATS - 1));
endmodule

// File: rtl/dram_cmd_seq.sv
module dram_cmd_seq import dcs_pkg::*; #(
  parameter int NUM_RANKS = 2,
  parameter int NUM_BANKS = 8,
  parameter int ROW_W     = 14,
  parameter int COL_W     = 11,
  parameter int BEATS     = 8,
  parameter int T_RCD     = 3,
  parameter int T_RP      = 4,
  parameter int T_RAS     = 16,
  localparam int RANK_W   = (NUM_RANKS > 1) ? $clog2(NUM_RANKS) : 1,
  localparam int BANK_W   = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [1:0]        req_op,
  input  logic [RANK_W-1:0] req_rank,
  input  logic [BANK_W-1:0] req_bank,
  input  logic [ROW_W-1:0]  req_row,
  input  logic [COL_W-1:0]  req_col,
  output logic [2:0]        cmd_o,
  output logic [RANK_W-1:0] cmd_cs_o,
  output logic [BANK_W-1:0] cmd_bank_o,
  output logic [ROW_W-1:0]  cmd_addr_o,
  output logic              done_o
);
  localparam int SLOT_W = RANK_W + BANK_W;
  localparam int NSLOT  = 1 << SLOT_W;
  localparam int BEAT_W = $clog2(BEATS);
  localparam int HI_W   = COL_W - BEAT_W;
  localparam int TMAX   = (T_RAS > T_RCD) ? ((T_RAS > T_RP) ? T_RAS : T_RP)
                                          : ((T_RCD > T_RP) ? T_RCD : T_RP);
  localparam int CNT_W  = $clog2(TMAX + 1);

  seq_state_e        state;
  op_e               op_q, op_in;
  logic [RANK_W-1:0] rank_q;
  logic [BANK_W-1:0] bank_q;
  logic [SLOT_W-1:0] slot_q;
  logic [ROW_W-1:0]  row_q;
  logic [HI_W-1:0]   colhi_q;
  cmd_e              cmd_q;

  logic [NSLOT-1:0]  open_v, rcd_ok_v, rp_ok_v, ras_ok_v, act_v, pre_v;
  logic [ROW_W-1:0]  row_v [NSLOT];
  logic              issue_pre, issue_act, issue_col, accept;
  logic [BEAT_W-1:0] beat;
  logic              beat_last;

  for (genvar g = 0; g < NSLOT; g++) begin : g_bank
    dcs_bank_track #(
      .ROW_W(ROW_W), .CNT_W(CNT_W),
      .T_RCD(T_RCD), .T_RP(T_RP), .T_RAS(T_RAS)
    ) u_trk (
      .clk      (clk),
      .rst      (rst),
      .act_i    (act_v[g]),
      .pre_i    (pre_v[g]),
      .row_i    (row_q),
      .open_o   (open_v[g]),
      .row_o    (row_v[g]),
      .rcd_ok_o (rcd_ok_v[g]),
      .rp_ok_o  (rp_ok_v[g]),
      .ras_ok_o (ras_ok_v[g])
    );
  end

  dcs_beat_ctr #(.BEATS(BEATS), .BEAT_W(BEAT_W)) u_beat (
    .clk    (clk),
    .rst    (rst),
    .clr_i  (accept),
    .inc_i  (issue_col),
    .beat_o (beat),
    .last_o (beat_last)
  );

  always_comb begin
    op_in = (req_op == 2'd2) ? OP_CLOSE : (req_op == 2'd1) ? OP_WR : OP_RD;
    accept    = req_valid && (state == S_IDLE);
    issue_pre = (state == S_PRE) && ras_ok_v[slot_q];
    issue_act = (state == S_ACT) && rp_ok_v[slot_q];
    issue_col = (state == S_COL) && rcd_ok_v[slot_q];
    act_v = issue_act ? (NSLOT'(1) << slot_q) : '0;
    pre_v = issue_pre ? (NSLOT'(1) << slot_q) : '0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= S_IDLE;
      op_q    <= OP_RD;
      rank_q  <= '0;
      bank_q  <= '0;
      slot_q  <= '0;
      row_q   <= '0;
      colhi_q <= '0;
    end else begin
      case (state)
        S_IDLE: if (accept) begin
          op_q    <= op_in;
          rank_q  <= req_rank;
          bank_q  <= req_bank;
          slot_q  <= {req_rank, req_bank};
          row_q   <= req_row;
          colhi_q <= req_col[COL_W-1:BEAT_W];
          state   <= S_DECIDE;
        end
        S_DECIDE: begin
          if (op_q == OP_CLOSE)             state <= open_v[slot_q] ? S_PRE : S_IDLE;
          else if (!open_v[slot_q])         state <= S_ACT;
          else if (row_v[slot_q] == row_q)  state <= S_COL;
          else                              state <= S_PRE;
        end
        S_PRE: if (issue_pre) state <= (op_q == OP_CLOSE) ? S_IDLE : S_ACT;
        S_ACT: if (issue_act) state <= S_COL;
        S_COL: if (issue_col && beat_last) state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cmd_q      <= CMD_NOP;
      cmd_cs_o   <= '0;
      cmd_bank_o <= '0;
      cmd_addr_o <= '0;
      done_o     <= 1'b0;
    end else begin
      cmd_cs_o   <= rank_q;
      cmd_bank_o <= bank_q;
      done_o     <= issue_col && beat_last;
      if (issue_pre) begin
        cmd_q      <= CMD_PRE;
        cmd_addr_o <= '0;
      end else if (issue_act) begin
        cmd_q      <= CMD_ACT;
        cmd_addr_o <= row_q;
      end else if (issue_col) begin
        cmd_q      <= (op_q == OP_WR) ? CMD_WR : CMD_RD;
        cmd_addr_o <= ROW_W'({colhi_q, beat});
      end else begin
        cmd_q      <= CMD_NOP;
        cmd_addr_o <= '0;
      end
    end
  end

  assign cmd_o     = cmd_q;
  assign req_ready = (state == S_IDLE);
endmodule

// File: rtl/dcs_chk.sv
module dcs_chk #(
  parameter int NUM_RANKS = 2,
  parameter int NUM_BANKS = 8,
  parameter int T_RCD     = 3,
  parameter int T_RP      = 4,
  parameter int T_RAS     = 16,
  localparam int RANK_W   = (NUM_RANKS > 1) ? $clog2(NUM_RANKS) : 1,
  localparam int BANK_W   = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
  input logic              clk,
  input logic              rst,
  input logic              req_valid,
  input logic              req_ready,
  input logic [2:0]        cmd_o,
  input logic [RANK_W-1:0] cmd_cs_o,
  input logic [BANK_W-1:0] cmd_bank_o,
  input logic              done_o
);
  localparam int NSLOT = 1 << (RANK_W + BANK_W);

  logic [7:0] since_act [NSLOT];
  logic [7:0] since_pre [NSLOT];
  logic [NSLOT-1:0] is_open;
  logic [RANK_W+BANK_W-1:0] slot;
  logic [7:0] sa_sel, sp_sel;
  logic open_sel, is_col;

  always_comb begin
    slot     = {cmd_cs_o, cmd_bank_o};
    sa_sel   = since_act[slot];
    sp_sel   = since_pre[slot];
    open_sel = is_open[slot];
    is_col   = (cmd_o == 3'd2) || (cmd_o == 3'd3);
  end

  for (genvar g = 0; g < NSLOT; g++) begin : g_mon
    always_ff @(posedge clk) begin
      if (rst) begin
        since_act[g] <= 8'hff;
        since_pre[g] <= 8'hff;
        is_open[g]   <= 1'b0;
      end else begin
        if (cmd_o == 3'd1 && slot == g) begin
          since_act[g] <= 8'd1;
          is_open[g]   <= 1'b1;
        end else if (since_act[g] != 8'hff) begin
          since_act[g] <= since_act[g] + 8'd1;
        end
        if (cmd_o == 3'd4 && slot == g) begin
          since_pre[g] <= 8'd1;
          is_open[g]   <= 1'b0;
        end else if (since_pre[g] != 8'hff) begin
          since_pre[g] <= since_pre[g] + 8'd1;
        end
      end
    end
  end

  p_reset_nop_r1: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (cmd_o == 3'd0 && !done_o && req_ready));
  p_col_needs_open_r3: assert property (@(posedge clk) disable iff (rst)
    is_col |-> open_sel);
  p_act_needs_closed_r4: assert property (@(posedge clk) disable iff (rst)
    (cmd_o == 3'd1) |-> !open_sel);
  p_done_with_col_r6: assert property (@(posedge clk) disable iff (rst)
    done_o |-> is_col);
  p_col_after_rcd_r7: assert property (@(posedge clk) disable iff (rst)
    is_col |-> (sa_sel >= 8'(T_RCD)));
  p_act_after_rp_r8: assert property (@(posedge clk) disable iff (rst)
    (cmd_o == 3'd1) |-> (sp_sel >= 8'(T_RP)));
  p_pre_after_ras_r9: assert property (@(posedge clk) disable iff (rst)
    (cmd_o == 3'd4) |-> (sa_sel >= 8'(T_RAS)));
  p_pre_needs_open_r10: assert property (@(posedge clk) disable iff (rst)
    (cmd_o == 3'd4) |-> open_sel);
  p_ready_drop_r13: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready) |=> !req_ready);
endmodule

bind dram_cmd_seq dcs_chk #(
  .NUM_RANKS(NUM_RANKS), .NUM_BANKS(NUM_BANKS),
  .T_RCD(T_RCD), .T_RP(T_RP), .T_RAS(T_RAS)
) u_chk (
  .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
  .cmd_o(cmd_o), .cmd_cs_o(cmd_cs_o), .cmd_bank_o(cmd_bank_o), .done_o(done_o)
);

// File: tb/dram_cmd_seq_bench.sv
module dram_cmd_seq_bench;
  localparam int T_RCD = 3;
  localparam int T_RP  = 4;
  localparam int T_RAS = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req_valid = 1'b0;
  logic req_ready;
  logic [1:0] req_op = '0;
  logic [0:0] req_rank = '0;
  logic [2:0] req_bank = '0;
  logic [13:0] req_row = '0;
  logic [10:0] req_col = '0;
  logic [2:0] cmd_o;
  logic [0:0] cmd_cs_o;
  logic [2:0] cmd_bank_o;
  logic [13:0] cmd_addr_o;
  logic done_o;

  dram_cmd_seq #(.T_RCD(T_RCD), .T_RP(T_RP), .T_RAS(T_RAS)) u_dram_cmd_seq (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_op(req_op), .req_rank(req_rank), .req_bank(req_bank),
    .req_row(req_row), .req_col(req_col), .cmd_o(cmd_o),
    .cmd_cs_o(cmd_cs_o), .cmd_bank_o(cmd_bank_o), .cmd_addr_o(cmd_addr_o),
    .done_o(done_o)
  );

  always #10 clk = ~clk;

  int cyc = 0;
  int checks = 0;
  int errors = 0;
  int n = 0;
  int dn = 0;
  int dcyc = 0;
  int lg_cmd [64];
  int lg_cs [64];
  int lg_bank [64];
  int lg_addr [64];
  int lg_cyc [64];

  task automatic report();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 20000) begin
      errors = errors + 1;
      $display("FAIL watchdog: actual %0d cycles expected under 20000", cyc);
      report();
    end
  end

  always @(negedge clk) begin
    if (!rst) begin
      if (cmd_o != 3'd0 && n < 64) begin
        lg_cmd[n]  = cmd_o;
        lg_cs[n]   = cmd_cs_o;
        lg_bank[n] = cmd_bank_o;
        lg_addr[n] = cmd_addr_o;
        lg_cyc[n]  = cyc;
        n = n + 1;
      end
      if (done_o) begin
        dn = dn + 1;
        dcyc = cyc;
      end
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks = checks + 1;
    if (!ok) begin
      errors = errors + 1;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic clear_log();
    n = 0;
    dn = 0;
  endtask

  task automatic send(input int op, input int rank, input int bank, input int row, input int col);
    int guard;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1;
    req_op    = 2'(op);
    req_rank  = 1'(rank);
    req_bank  = 3'(bank);
    req_row   = 14'(row);
    req_col   = 11'(col);
    @(negedge clk);
    req_valid = 1'b0;
    guard = 0;
    while (!req_ready && guard < 200) begin
      @(negedge clk);
      guard++;
    end
    @(negedge clk);
  endtask

  // check a burst of 8 column commands starting at log index s
  task automatic chk_burst(input int s, input int code, input int colhi, input int cs,
                           input int bank, input string req);
    for (int k = 0; k < 8; k++) begin
      chk(lg_cmd[s+k] == code && lg_addr[s+k] == colhi * 8 + k &&
          lg_cs[s+k] == cs && lg_bank[s+k] == bank, req, lg_addr[s+k], colhi * 8 + k);
      if (k > 0) chk(lg_cyc[s+k] == lg_cyc[s+k-1] + 1, "R5 consecutive beats",
                     lg_cyc[s+k] - lg_cyc[s+k-1], 1);
    end
  endtask

  task automatic t_reset();
    chk(cmd_o == 3'd0, "R1 cmd nop after reset", cmd_o, 0);
    chk(req_ready == 1'b1, "R1 ready after reset", req_ready, 1);
    chk(done_o == 1'b0, "R1 done low after reset", done_o, 0);
  endtask

  task automatic t_closed();
    clear_log();
    send(0, 0, 1, 100, 'h25);
    chk(n == 9, "R2 closed read count", n, 9);
    chk(lg_cmd[0] == 1 && lg_addr[0] == 100, "R2 act with row", lg_addr[0], 100);
    chk(lg_cyc[1] - lg_cyc[0] >= T_RCD, "R7 act to column gap", lg_cyc[1] - lg_cyc[0], T_RCD);
    chk_burst(1, 2, 4, 0, 1, "R5 read beats");
    chk(dn == 1 && dcyc == lg_cyc[8], "R6 done on last beat", dcyc, lg_cyc[8]);
  endtask

  task automatic t_hit();
    clear_log();
    send(1, 0, 1, 100, 'h40);
    chk(n == 8, "R3 hit issues only columns", n, 8);
    chk_burst(0, 3, 8, 0, 1, "R5 write beats");
    chk(dn == 1, "R6 one done per line", dn, 1);
  endtask

  task automatic t_conflict();
    clear_log();
    send(0, 0, 3, 7, 0);
    send(0, 0, 3, 9, 'h18);
    chk(n == 19, "R4 conflict count", n, 19);
    chk(lg_cmd[9] == 4 && lg_bank[9] == 3, "R4 precharge first", lg_cmd[9], 4);
    chk(lg_cmd[10] == 1 && lg_addr[10] == 9, "R4 act new row", lg_addr[10], 9);
    chk(lg_cyc[9] - lg_cyc[0] >= T_RAS, "R9 act to precharge gap", lg_cyc[9] - lg_cyc[0], T_RAS);
    chk(lg_cyc[10] - lg_cyc[9] >= T_RP, "R8 precharge to act gap", lg_cyc[10] - lg_cyc[9], T_RP);
    chk_burst(11, 2, 3, 0, 3, "R4 column after reopen");
    chk(dn == 2, "R6 done per line", dn, 2);
  endtask

  task automatic t_close_open();
    clear_log();
    send(2, 0, 3, 0, 0);
    chk(n == 1 && lg_cmd[0] == 4 && lg_bank[0] == 3, "R10 close issues precharge", n, 1);
    chk(dn == 0, "R10 close gives no done", dn, 0);
    send(0, 0, 3, 9, 0);
    chk(n == 10 && lg_cmd[1] == 1, "R10 bank closed after close", lg_cmd[1], 1);
    chk(lg_cyc[1] - lg_cyc[0] >= T_RP, "R8 close to act gap", lg_cyc[1] - lg_cyc[0], T_RP);
  endtask

  task automatic t_close_closed();
    clear_log();
    send(2, 0, 6, 0, 0);
    chk(n == 0, "R11 close of closed bank silent", n, 0);
    chk(dn == 0, "R11 no done", dn, 0);
    chk(req_ready == 1'b1, "R11 ready back", req_ready, 1);
  endtask

  task automatic t_rank();
    clear_log();
    send(0, 1, 1, 100, 0);
    chk(n == 9 && lg_cmd[0] == 1, "R12 other rank still closed", lg_cmd[0], 1);
    chk(lg_cs[0] == 1 && lg_bank[0] == 1, "R12 chip select follows rank", lg_cs[0], 1);
    clear_log();
    send(0, 0, 1, 100, 0);
    chk(n == 8 && lg_cmd[0] == 2 && lg_cs[0] == 0, "R12 rank0 row kept open", lg_cmd[0], 2);
  endtask

  task automatic t_busy();
    int lows;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1;
    req_op = 2'd0; req_rank = 1'd0; req_bank = 3'd5; req_row = 14'd42; req_col = 11'd0;
    @(negedge clk);
    req_valid = 1'b0;
    lows = 0;
    while (!req_ready && lows < 200) begin
      lows++;
      @(negedge clk);
    end
    chk(lows >= 12, "R13 ready low while busy", lows, 12);
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_closed();
    t_hit();
    t_conflict();
    t_close_open();
    t_close_closed();
    t_rank();
    t_busy();
    report();
  end
endmodule